// File: doc/BRIEF.md
# SDRAM Bank Activation Timing Guard

This block sits in front of the command path of a four-bank SDRAM controller. Each cycle it decides whether the command the scheduler wants to issue is legal. It keeps the open or closed state of every bank and the row each bank holds. It also runs the timers that keep activations and column accesses apart. A legal request is granted in the same cycle it is presented. An illegal one is stalled, and the scheduler holds it until the guard grants it.

Each bank has its own state machine with three states:

- **IDLE**: the bank is closed.
- **OPENING**: a row has been activated, and the activate-to-column delay is still running.
- **READY**: the row is open and column accesses are allowed.

The transitions are:

- IDLE to OPENING on a granted ACTIVE.
- OPENING to READY when the activate-to-column counter reaches zero.
- OPENING to IDLE, or READY to IDLE, on a PRECHARGE.

Each bank also has a row-cycle down-counter. One shared counter spaces activations to different banks. The timing limits are given in picoseconds. At elaboration they are turned into cycle counts by ceiling division by the clock period, with a floor of one cycle. With the defaults (8000 ps clock; 67000, 19000 and 15000 ps limits) the counts are:

| Timer | Cycles |
|---|---|
| Row cycle (TRC_CYC) | 9 |
| Activate-to-column (TRCD_CYC) | 3 |
| Activate-to-activate across banks (TRRD_CYC) | 2 |

Top module: `sdram_act_guard`

## Requirements
- R1: Each timing limit in cycles is ceil(limit_ps / CLK_PERIOD_PS), at least 1. With the defaults: TRC_CYC=9, TRCD_CYC=3, TRRD_CYC=2.
- R2: The command codes on `req_cmd` are 0 NOP, 1 ACTIVE, 2 READ, 3 WRITE and 4 PRECHARGE. For codes 1 to 4, exactly one of `grant` and `stall` is high, combinationally in the same cycle. For codes 0 and 5 to 7, both are low.
- R3: A READ or WRITE to a bank that is closed is stalled.
- R4: Take an ACTIVE to bank b granted in cycle k. A READ or WRITE to bank b is stalled in cycles k+1 to k+TRCD_CYC-1, and granted from cycle k+TRCD_CYC on.
- R5: After an ACTIVE to bank b granted in cycle k, a new ACTIVE to bank b is stalled before cycle k+TRC_CYC. This holds even if bank b was precharged in between.
- R6: After any ACTIVE granted in cycle k, an ACTIVE to another bank is stalled before cycle k+TRRD_CYC. It is granted from then on if that bank is closed and its own row-cycle time has passed.
- R7: An ACTIVE to a bank that is open is stalled, whatever the timers show, until the bank is precharged.
- R8: A granted ACTIVE raises `bank_open[b]` in the next cycle and loads the request row into slot b of `open_row` (bits b*13+12 down to b*13). A stalled ACTIVE changes neither.
- R9: A PRECHARGE is always granted. In the next cycle `bank_open[b]` is low and slot b of `open_row` reads zero. A PRECHARGE to a bank that is already closed changes nothing.
- R10: After synchronous reset, all banks are closed, `open_row` is zero and all timers are zero. An ACTIVE to any bank in the first cycle after reset is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_cmd | input | 3 | Requested command code |
| req_bank | input | 2 | Bank addressed by the request |
| req_row | input | 13 | Row address, used by ACTIVE |
| grant | output | 1 | Request is legal and is issued this cycle |
| stall | output | 1 | Request is illegal and must be held |
| bank_open | output | 4 | One flag per bank, high while a row is open |
| open_row | output | 52 | Open row of each bank, 13 bits per bank, bank 0 in the lowest bits |

## Verification
The bench sweeps the distance between an ACTIVE and the request that follows it, one cycle at a time, for every bank and every ordered pair of banks. This pins down the exact first legal cycle for column access, same-bank reactivation and cross-bank activation. A counter loaded with N instead of N-1, or a comparison off by one, would grant one cycle early or stall one cycle too long, and that shows at the boundary step. The sweep that precharges right after activating catches a design that resets the row-cycle timer on precharge: it would reactivate the bank too early. Directed cases cover the remaining faults:

- An ACTIVE to a bank that is still open: a design that checks only the timers would wrongly reopen it.
- A repeated PRECHARGE: a wrong design would disturb the bank state.
- Unused command codes: a wrong design would grant or stall on them.

// File: rtl/sdram_guard_pkg.sv
package sdram_guard_pkg;

    localparam logic [2:0] CMD_NOP = 3'd0;
    localparam logic [2:0] CMD_ACT = 3'd1;
    localparam logic [2:0] CMD_RD  = 3'd2;
    localparam logic [2:0] CMD_WR  = 3'd3;
    localparam logic [2:0] CMD_PRE = 3'd4;

    typedef enum logic [1:0] {
        BK_IDLE    = 2'd0,
        BK_OPENING = 2'd1,
        BK_READY   = 2'd2
    } bank_state_e;

    // R1: ceiling division of a limit by the clock period, never below one cycle
    function automatic int cyc_from_ps(input int limit_ps, input int period_ps);
        int r;
        r = (limit_ps + period_ps - 1) / period_ps;
        if (r < 1) begin
            r = 1;
        end
        return r;
    endfunction

endpackage

// File: rtl/sdram_bank_fsm.sv
module sdram_bank_fsm
    import sdram_guard_pkg::*;
#(
    parameter int ROW_W    = 13,
    parameter int TRC_CYC  = 9,
    parameter int TRCD_CYC = 3,
    parameter int CNT_W    = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             act_fire,
    input  logic             pre_fire,
    input  logic [ROW_W-1:0] row_in,
    output logic             is_open,
    output logic             act_ok,
    output logic             col_ok,
    output logic [ROW_W-1:0] row_q
);

    localparam logic [CNT_W-1:0] TRC_LOAD  = CNT_W'(TRC_CYC - 1);
    localparam logic [CNT_W-1:0] TRCD_LOAD = CNT_W'(TRCD_CYC - 1);

    bank_state_e      state_q;
    bank_state_e      state_d;
    logic [CNT_W-1:0] trc_q;
    logic [CNT_W-1:0] trcd_q;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= BK_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BK_IDLE: begin
                if (act_fire) begin
                    state_d = BK_OPENING;
                end
            end
            BK_OPENING: begin
                if (pre_fire) begin
                    state_d = BK_IDLE;
                end else if (trcd_q == '0) begin
                    state_d = BK_READY;
                end
            end
            BK_READY: begin
                if (pre_fire) begin
                    state_d = BK_IDLE;
                end
            end
            default: state_d = BK_IDLE;
        endcase
    end

    // timers: loaded with count-1 so that the limit expires exactly N cycles on
    always_ff @(posedge clk) begin
        if (rst) begin
            trc_q  <= '0;
            trcd_q <= '0;
        end else begin
            if (act_fire) begin
                trc_q <= TRC_LOAD;
            end else if (trc_q != '0) begin
                trc_q <= trc_q - 1'b1;
            end
            if (act_fire) begin
                trcd_q <= TRCD_LOAD;
            end else if (trcd_q != '0) begin
                trcd_q <= trcd_q - 1'b1;
            end
        end
    end

    // row register
    always_ff @(posedge clk) begin
        if (rst) begin
            row_q <= '0;
        end else if (act_fire) begin
            row_q <= row_in;
        end else if (pre_fire) begin
            row_q <= '0;
        end
    end

    // outputs
    always_comb begin
        is_open = 1'b0;
        act_ok  = 1'b0;
        col_ok  = 1'b0;
        unique case (state_q)
            BK_IDLE: begin
                act_ok = (trc_q == '0);
            end
            BK_OPENING: begin
                is_open = 1'b1;
                col_ok  = (trcd_q == '0);
            end
            BK_READY: begin
                is_open = 1'b1;
                col_ok  = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/sdram_rrd_timer.sv
module sdram_rrd_timer #(
    parameter int TRRD_CYC = 2,
    parameter int CNT_W    = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic act_fire,
    output logic ready
);

    localparam logic [CNT_W-1:0] TRRD_LOAD = CNT_W'(TRRD_CYC - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (act_fire) begin
            cnt_q <= TRRD_LOAD;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign ready = (cnt_q == '0);

endmodule

// File: rtl/sdram_act_guard.sv
module sdram_act_guard
    import sdram_guard_pkg::*;
#(
    parameter int BANK_W        = 2,
    parameter int ROW_W         = 13,
    parameter int CLK_PERIOD_PS = 8000,
    parameter int T_RC_PS       = 67000,
    parameter int T_RCD_PS      = 19000,
    parameter int T_RRD_PS      = 15000
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [2:0]                    req_cmd,
    input  logic [BANK_W-1:0]             req_bank,
    input  logic [ROW_W-1:0]              req_row,
    output logic                          grant,
    output logic                          stall,
    output logic [(1<<BANK_W)-1:0]        bank_open,
    output logic [(1<<BANK_W)*ROW_W-1:0]  open_row
);

    localparam int NUM_BANKS = 1 << BANK_W;
    localparam int TRC_CYC   = cyc_from_ps(T_RC_PS, CLK_PERIOD_PS);
    localparam int TRCD_CYC  = cyc_from_ps(T_RCD_PS, CLK_PERIOD_PS);
    localparam int TRRD_CYC  = cyc_from_ps(T_RRD_PS, CLK_PERIOD_PS);
    localparam int MAX_CYC   = (TRC_CYC > TRCD_CYC) ?
                               ((TRC_CYC > TRRD_CYC) ? TRC_CYC : TRRD_CYC) :
                               ((TRCD_CYC > TRRD_CYC) ? TRCD_CYC : TRRD_CYC);
    localparam int CNT_W     = $clog2(MAX_CYC + 1);

    logic [NUM_BANKS-1:0] act_ok;
    logic [NUM_BANKS-1:0] col_ok;
    logic [NUM_BANKS-1:0] act_fire;
    logic [NUM_BANKS-1:0] pre_fire;
    logic                 rrd_ok;
    logic                 any_act;
    logic                 legal;

    // command decision
    always_comb begin
        grant = 1'b0;
        stall = 1'b0;
        legal = 1'b0;
        case (req_cmd)
            CMD_ACT: begin
                legal = act_ok[req_bank] && rrd_ok;
                grant = legal;
                stall = !legal;
            end
            CMD_RD, CMD_WR: begin
                legal = col_ok[req_bank];
                grant = legal;
                stall = !legal;
            end
            CMD_PRE: begin
                legal = 1'b1;
                grant = 1'b1;
            end
            default: ;
        endcase
    end

    always_comb begin
        act_fire = '0;
        pre_fire = '0;
        if (grant && (req_cmd == CMD_ACT)) begin
            act_fire[req_bank] = 1'b1;
        end
        if (grant && (req_cmd == CMD_PRE)) begin
            pre_fire[req_bank] = 1'b1;
        end
    end

    assign any_act = |act_fire;

    sdram_rrd_timer #(
        .TRRD_CYC (TRRD_CYC),
        .CNT_W    (CNT_W)
    ) u_rrd (
        .clk      (clk),
        .rst      (rst),
        .act_fire (any_act),
        .ready    (rrd_ok)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        sdram_bank_fsm #(
            .ROW_W    (ROW_W),
            .TRC_CYC  (TRC_CYC),
            .TRCD_CYC (TRCD_CYC),
            .CNT_W    (CNT_W)
        ) u_fsm (
            .clk      (clk),
            .rst      (rst),
            .act_fire (act_fire[b]),
            .pre_fire (pre_fire[b]),
            .row_in   (req_row),
            .is_open  (bank_open[b]),
            .act_ok   (act_ok[b]),
            .col_ok   (col_ok[b]),
            .row_q    (open_row[b*ROW_W +: ROW_W])
        );
    end

endmodule

// File: rtl/sdram_act_guard_chk.sv
module sdram_act_guard_chk
    import sdram_guard_pkg::*;
#(
    parameter int BANK_W        = 2,
    parameter int ROW_W         = 13,
    parameter int CLK_PERIOD_PS = 8000,
    parameter int T_RC_PS       = 67000,
    parameter int T_RCD_PS      = 19000,
    parameter int T_RRD_PS      = 15000
) (
    input logic                     clk,
    input logic                     rst,
    input logic [2:0]               req_cmd,
    input logic [BANK_W-1:0]        req_bank,
    input logic                     grant,
    input logic                     stall,
    input logic [(1<<BANK_W)-1:0]   bank_open
);

    localparam int NUM_BANKS = 1 << BANK_W;
    localparam int C_RC  = cyc_from_ps(T_RC_PS, CLK_PERIOD_PS);
    localparam int C_RCD = cyc_from_ps(T_RCD_PS, CLK_PERIOD_PS);
    localparam int C_RRD = cyc_from_ps(T_RRD_PS, CLK_PERIOD_PS);
    localparam logic [15:0] SAT = 16'hFFFF;

    logic [15:0] since_bank [NUM_BANKS];
    logic [15:0] since_any;
    logic        is_act_g;

    assign is_act_g = grant && (req_cmd == CMD_ACT);

    always_ff @(posedge clk) begin
        if (rst) begin
            since_any <= SAT;
            for (int b = 0; b < NUM_BANKS; b++) begin
                since_bank[b] <= SAT;
            end
        end else begin
            if (is_act_g) begin
                since_any <= 16'd1;
            end else if (since_any != SAT) begin
                since_any <= since_any + 16'd1;
            end
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (is_act_g && (int'(req_bank) == b)) begin
                    since_bank[b] <= 16'd1;
                end else if (since_bank[b] != SAT) begin
                    since_bank[b] <= since_bank[b] + 16'd1;
                end
            end
        end
    end

    a_r2_grant_stall_excl: assert property (@(posedge clk) disable iff (rst)
        !(grant && stall));

    a_r2_unused_code_quiet: assert property (@(posedge clk) disable iff (rst)
        (req_cmd == CMD_NOP || req_cmd > CMD_PRE) |-> (!grant && !stall));

    a_r9_pre_always_granted: assert property (@(posedge clk) disable iff (rst)
        (req_cmd == CMD_PRE) |-> grant);

    a_r3_col_needs_open: assert property (@(posedge clk) disable iff (rst)
        ((req_cmd == CMD_RD || req_cmd == CMD_WR) && grant) |-> bank_open[req_bank]);

    a_r4_col_after_rcd: assert property (@(posedge clk) disable iff (rst)
        ((req_cmd == CMD_RD || req_cmd == CMD_WR) && grant) |->
            (since_bank[req_bank] >= 16'(C_RCD)));

    a_r5_act_after_rc: assert property (@(posedge clk) disable iff (rst)
        is_act_g |-> (since_bank[req_bank] >= 16'(C_RC)));

    a_r6_act_after_rrd: assert property (@(posedge clk) disable iff (rst)
        is_act_g |-> (since_any >= 16'(C_RRD)));

    a_r7_no_act_on_open: assert property (@(posedge clk) disable iff (rst)
        ((req_cmd == CMD_ACT) && bank_open[req_bank]) |-> stall);

    a_r8_open_after_act: assert property (@(posedge clk) disable iff (rst)
        is_act_g |=> bank_open[$past(req_bank)]);

    a_r9_closed_after_pre: assert property (@(posedge clk) disable iff (rst)
        (req_cmd == CMD_PRE) |=> !bank_open[$past(req_bank)]);

endmodule

bind sdram_act_guard sdram_act_guard_chk #(
    .BANK_W        (BANK_W),
    .ROW_W         (ROW_W),
    .CLK_PERIOD_PS (CLK_PERIOD_PS),
    .T_RC_PS       (T_RC_PS),
    .T_RCD_PS      (T_RCD_PS),
    .T_RRD_PS      (T_RRD_PS)
) u_guard_chk (
    .clk       (clk),
    .rst       (rst),
    .req_cmd   (req_cmd),
    .req_bank  (req_bank),
    .grant     (grant),
    .stall     (stall),
    .bank_open (bank_open)
);

// File: tb/sdram_act_guard_tb.sv
module sdram_act_guard_tb_top;

    localparam int PERIOD_PS = 8000;
    localparam int RC_PS     = 67000;
    localparam int RCD_PS    = 19000;
    localparam int RRD_PS    = 15000;
    // R1: expected cycle counts computed here by ceiling division
    localparam int E_RC  = (RC_PS  + PERIOD_PS - 1) / PERIOD_PS;
    localparam int E_RCD = (RCD_PS + PERIOD_PS - 1) / PERIOD_PS;
    localparam int E_RRD = (RRD_PS + PERIOD_PS - 1) / PERIOD_PS;

    localparam logic [2:0] NOP = 3'd0;
    localparam logic [2:0] ACT = 3'd1;
    localparam logic [2:0] RD  = 3'd2;
    localparam logic [2:0] WR  = 3'd3;
    localparam logic [2:0] PRE = 3'd4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  req_cmd = 3'd0;
    logic [1:0]  req_bank = 2'd0;
    logic [12:0] req_row = 13'd0;
    logic        grant;
    logic        stall;
    logic [3:0]  bank_open;
    logic [51:0] open_row;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sdram_act_guard #(
        .CLK_PERIOD_PS (PERIOD_PS),
        .T_RC_PS       (RC_PS),
        .T_RCD_PS      (RCD_PS),
        .T_RRD_PS      (RRD_PS)
    ) dut_i (
        .clk       (clk),
        .rst       (rst),
        .req_cmd   (req_cmd),
        .req_bank  (req_bank),
        .req_row   (req_row),
        .grant     (grant),
        .stall     (stall),
        .bank_open (bank_open),
        .open_row  (open_row)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // present a request for one cycle, starting just after a rising edge
    task automatic drive(input logic [2:0] c, input logic [1:0] b, input logic [12:0] r);
        @(posedge clk);
        #1;
        req_cmd  = c;
        req_bank = b;
        req_row  = r;
    endtask

    // sample the same-cycle grant/stall response at the falling edge
    task automatic expect_gs(input string req, input logic g, input logic s);
        @(negedge clk);
        check(req, {62'd0, grant, stall}, {62'd0, g, s});
    endtask

    task automatic do_reset();
        drive(NOP, 2'd0, 13'd0);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        rst = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            drive(NOP, 2'd0, 13'd0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        do_reset();

        // R10: reset state
        @(negedge clk);
        check("R10 bank_open", {60'd0, bank_open}, 64'd0);
        check("R10 open_row", {12'd0, open_row}, 64'd0);
        check("R10 nop quiet", {62'd0, grant, stall}, 64'd0);

        // R2: unused codes and NOP neither grant nor stall
        for (int c = 5; c < 8; c++) begin
            drive(3'(c), 2'(c), 13'd1);
            expect_gs("R2 unused code", 1'b0, 1'b0);
        end
        drive(NOP, 2'd3, 13'd0);
        expect_gs("R2 nop", 1'b0, 1'b0);

        // R3: column access to a closed bank
        drive(RD, 2'd2, 13'd0);
        expect_gs("R3 read closed", 1'b0, 1'b1);
        drive(WR, 2'd1, 13'd0);
        expect_gs("R3 write closed", 1'b0, 1'b1);

        // R7 / R8 / R9 directed sequence
        drive(ACT, 2'd0, 13'd5);
        expect_gs("R10 first act granted", 1'b1, 1'b0);
        drive(NOP, 2'd0, 13'd0);
        @(negedge clk);
        check("R8 open flag", {63'd0, bank_open[0]}, 64'd1);
        check("R8 open row", {51'd0, open_row[12:0]}, 64'd5);
        idle(E_RC + 2);
        drive(ACT, 2'd0, 13'd6);
        expect_gs("R7 act on open bank", 1'b0, 1'b1);
        drive(NOP, 2'd0, 13'd0);
        @(negedge clk);
        check("R8 stalled act keeps row", {51'd0, open_row[12:0]}, 64'd5);
        drive(PRE, 2'd0, 13'd0);
        expect_gs("R9 pre granted", 1'b1, 1'b0);
        drive(NOP, 2'd0, 13'd0);
        @(negedge clk);
        check("R9 closed after pre", {63'd0, bank_open[0]}, 64'd0);
        check("R9 row cleared", {51'd0, open_row[12:0]}, 64'd0);
        drive(PRE, 2'd0, 13'd0);
        expect_gs("R9 pre on closed granted", 1'b1, 1'b0);
        drive(NOP, 2'd0, 13'd0);
        @(negedge clk);
        check("R9 pre on closed no effect", {60'd0, bank_open}, 64'd0);
        drive(ACT, 2'd0, 13'd7);
        expect_gs("R5 reopen after rc", 1'b1, 1'b0);
        drive(NOP, 2'd0, 13'd0);
        @(negedge clk);
        check("R8 new row", {51'd0, open_row[12:0]}, 64'd7);

        // R4: sweep activate-to-column distance on every bank
        for (int b = 0; b < 4; b++) begin
            for (int d = 1; d <= E_RC + 3; d++) begin
                do_reset();
                drive(ACT, 2'(b), 13'(b * 100 + d));
                expect_gs("R10 act after reset", 1'b1, 1'b0);
                idle(d - 1);
                drive((d % 2 == 1) ? RD : WR, 2'(b), 13'd0);
                expect_gs("R4 col delay", (d >= E_RCD), (d < E_RCD));
            end
        end

        // R5: same-bank reactivation after an early precharge
        for (int b = 0; b < 4; b++) begin
            for (int d = 2; d <= E_RC + 3; d++) begin
                do_reset();
                drive(ACT, 2'(b), 13'd9);
                expect_gs("R10 act after reset", 1'b1, 1'b0);
                drive(PRE, 2'(b), 13'd0);
                expect_gs("R9 pre during opening", 1'b1, 1'b0);
                idle(d - 2);
                drive(ACT, 2'(b), 13'd10);
                expect_gs("R5 same bank act", (d >= E_RC), (d < E_RC));
            end
        end

        // R6: cross-bank activation spacing, every ordered pair
        for (int b = 0; b < 4; b++) begin
            for (int c = 0; c < 4; c++) begin
                if (c != b) begin
                    for (int d = 1; d <= E_RRD + 3; d++) begin
                        do_reset();
                        drive(ACT, 2'(b), 13'd1);
                        expect_gs("R10 act after reset", 1'b1, 1'b0);
                        idle(d - 1);
                        drive(ACT, 2'(c), 13'd2);
                        expect_gs("R6 cross bank act", (d >= E_RRD), (d < E_RRD));
                    end
                end
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule